// File: doc/BRIEF.md
# Chip Select Decoder with Fault Detection

This block turns a 24-bit bus address into four active-low chip selects. Each select has its own programmable region: a base address, a power-of-two size from 8 Kbytes to 16 Mbytes, an enable bit and a write-protect bit. The decode is combinational. While `bus_valid` is high, the select whose region holds `bus_addr` goes low in the same cycle.

The block watches for two kinds of bad access. An overlap conflict is an access that falls inside two or more enabled regions. A protection violation is a write into a write-protected region. Each fault sets a sticky status flag, whatever the control bits say. Each fault also raises `bus_err` for that cycle, but only when its own enable bit is set. On a conflict, no select is driven. On a violating write, the protected select stays high.

Select 2 can run as a peripheral select. In that mode its region is a fixed 64-Kbyte block, split into four 16-Kbyte quarters by address bits 15:14. Quarter 0 drives `cs_n[2]`. Quarters 1 to 3 drive the three shared pins, and each pin takes the select only when its own pin-enable bit is set. Otherwise the pin stays a general-purpose I/O line.

A simple register port gives access to the configuration and the status. Register writes happen on the clock edge. Register reads are combinational.

Top module: `cs_fault_decoder`

## Requirements
- R1: After reset, `cs_n` is 4'hF, `periph_cs_n` is 3'h7, `pin_mode` is 0 and `bus_err` is 0. The control register (address 4) and the status register (address 5) both read 0, and all selects are disabled.
- R2: A select drives low only while `bus_valid` is 1. It drives low when `bus_addr` matches the select's enabled region. A size code k (bits 3:0 of the select's register) means a region of 2^(13+k) bytes, and codes above 11 act as 11. The match compares the address bits at and above bit 13+k with the base address held in register bits 23:13.
- R3: An access that hits two or more enabled regions drives no select. It sets the conflict flag (status bit 0) at the next clock edge. The flag is set whatever the value of control bit 0.
- R4: During a conflicting access, `bus_err` is 1 in the same cycle only when the conflict enable (control bit 0) is 1. It is 0 when that bit is 0.
- R5: A write (`bus_write`=1) to a region whose write-protect bit (register bit 4) is set leaves that select high. It sets the protection flag (status bit 1) at the next edge. A read from the same region asserts the select as usual.
- R6: During a protection violation, `bus_err` is 1 in the same cycle only when the protection enable (control bit 1) is 1.
- R7: The status flags are sticky. A register write to address 5 clears each flag whose data bit is 1 and leaves a flag alone where the bit is 0. A flag being set in the same cycle takes priority over the clear.
- R8: With the peripheral enable (control bit 2) at 0, select 2 decodes its programmed region like any other select. In this mode `periph_cs_n` stays 3'h7 and `pin_mode` is 0.
- R9: With the peripheral enable at 1, select 2 covers a 64-Kbyte block whatever its size code. Address bits 15:14 pick the output: 0 drives `cs_n[2]`, and 1, 2 or 3 drive `periph_cs_n[0]`, `[1]` or `[2]`. A quarter whose pin is not enabled drives nothing.
- R10: `pin_mode[i]` is 1 exactly when the peripheral enable is 1 and pin enable bit i (control bit 4+i) is 1.
- R11: Select registers sit at addresses 0 to 3, with the layout base[23:13], enable bit 5, protect bit 4 and size bits 3:0. The control register sits at address 4. Every register reads back the value that was written to its defined fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | A bus access is in progress this cycle |
| bus_write | input | 1 | The access is a write |
| bus_addr | input | 24 | Access address |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | Register access is a write |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cs_n | output | 4 | Active-low chip selects 0 to 3 |
| periph_cs_n | output | 3 | Active-low peripheral selects for the three shared pins |
| pin_mode | output | 3 | 1 when a shared pin carries a peripheral select |
| bus_err | output | 1 | Single-cycle bus error, asserted during the faulting access |

## Verification
The region decode is tried with addresses inside a region, at its last byte, just past its end, and with `bus_valid` low. These cases separate the size-mask logic from the enable gating. Overlapping regions and protected regions are each accessed twice, once with the matching enable bit off and once with it on. This shows that the sticky flag and the bus error are gated separately, and the read/write pairs show that protection applies to writes only. The peripheral mode is exercised by walking all four quarters with one pin disabled, and then turning the mode off with the same address. This separates the forced 64-Kbyte block, the quarter steering and the per-pin enables from the plain decode.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    parameter int ADDR_W      = 24;
    parameter int NUM_CS      = 4;
    parameter int MIN_LOG2    = 13;
    parameter int NUM_PINS    = 3;
    parameter int PERIPH_CS   = 2;
    parameter int PERIPH_LOG2 = 16;
    parameter int REG_AW      = 4;
    parameter int DATA_W      = 32;

    localparam int BASE_W   = ADDR_W - MIN_LOG2;
    localparam int SIZE_W   = 4;
    localparam int CFG_WP   = 4;
    localparam int CFG_EN   = 5;
    localparam int PIN_LSB  = 4;
    localparam logic [REG_AW-1:0] REG_CTRL = REG_AW'(NUM_CS);
    localparam logic [REG_AW-1:0] REG_STAT = REG_AW'(NUM_CS + 1);

    typedef struct packed {
        logic              en;
        logic              wp;
        logic [SIZE_W-1:0] size;
        logic [BASE_W-1:0] base;
    } cs_cfg_t;

    typedef struct packed {
        logic                conf_en;
        logic                wp_en;
        logic                periph_en;
        logic [NUM_PINS-1:0] pin_en;
    } ctrl_t;

    typedef struct packed {
        logic conflict;
        logic wp_viol;
    } stat_t;
endpackage

// File: rtl/cfd_region_match.sv
module cfd_region_match
    import cfd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cs_cfg_t           cfg,
    input  logic              force_periph,
    output logic              hit
);
    localparam logic [SIZE_W-1:0] MAX_CODE = SIZE_W'(ADDR_W - MIN_LOG2);

    logic [4:0]        log2_sz;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_full;

    always_comb begin
        if (force_periph)
            log2_sz = 5'(PERIPH_LOG2);
        else if (cfg.size > MAX_CODE)
            log2_sz = 5'(ADDR_W);
        else
            log2_sz = 5'(MIN_LOG2) + {1'b0, cfg.size};
        mask      = {ADDR_W{1'b1}} << log2_sz;
        base_full = {cfg.base, {MIN_LOG2{1'b0}}};
        hit       = cfg.en && ((addr & mask) == (base_full & mask));
    end
endmodule

// File: rtl/cfd_select_out.sv
module cfd_select_out
    import cfd_pkg::*;
(
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [1:0]          quarter,
    input  logic [NUM_CS-1:0]   hit,
    input  logic [NUM_CS-1:0]   wp,
    input  ctrl_t               ctrl,
    output logic [NUM_CS-1:0]   cs_n,
    output logic [NUM_PINS-1:0] periph_cs_n,
    output logic [NUM_PINS-1:0] pin_mode,
    output logic                conflict,
    output logic                wp_viol,
    output logic                bus_err
);
    logic [NUM_CS-1:0] wp_blk;
    logic [NUM_CS-1:0] grant;

    always_comb begin
        wp_blk   = bus_write ? (hit & wp) : '0;
        conflict = bus_valid && ($countones(hit) > 1);
        wp_viol  = bus_valid && (|wp_blk);
        grant    = (bus_valid && !conflict) ? (hit & ~wp_blk) : '0;
        cs_n     = ~grant;
        if (ctrl.periph_en)
            cs_n[PERIPH_CS] = !(grant[PERIPH_CS] && (quarter == 2'd0));
        pin_mode = ctrl.periph_en ? ctrl.pin_en : '0;
        bus_err  = (conflict && ctrl.conf_en) || (wp_viol && ctrl.wp_en);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign periph_cs_n[p] = !(pin_mode[p] && grant[PERIPH_CS] &&
                                  (quarter == 2'(p + 1)));
    end
endmodule

// File: rtl/cfd_regfile.sv
module cfd_regfile
    import cfd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_en,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  set_conflict,
    input  logic                  set_wp,
    output cs_cfg_t [NUM_CS-1:0]  cfg,
    output ctrl_t                 ctrl,
    output stat_t                 stat,
    output logic [DATA_W-1:0]     reg_rdata
);
    typedef struct packed {
        cs_cfg_t [NUM_CS-1:0] cfg;
        ctrl_t                ctrl;
        stat_t                stat;
    } state_t;

    state_t st_d, st_q;
    logic   wr_hit;

    always_comb begin
        st_d   = st_q;
        wr_hit = reg_en && reg_wr;
        if (wr_hit) begin
            for (int i = 0; i < NUM_CS; i++) begin
                if (reg_addr == REG_AW'(i)) begin
                    st_d.cfg[i].base = reg_wdata[ADDR_W-1:MIN_LOG2];
                    st_d.cfg[i].en   = reg_wdata[CFG_EN];
                    st_d.cfg[i].wp   = reg_wdata[CFG_WP];
                    st_d.cfg[i].size = reg_wdata[SIZE_W-1:0];
                end
            end
            if (reg_addr == REG_CTRL) begin
                st_d.ctrl.conf_en   = reg_wdata[0];
                st_d.ctrl.wp_en     = reg_wdata[1];
                st_d.ctrl.periph_en = reg_wdata[2];
                st_d.ctrl.pin_en    = reg_wdata[PIN_LSB +: NUM_PINS];
            end
            if (reg_addr == REG_STAT) begin
                st_d.stat.conflict = st_q.stat.conflict & ~reg_wdata[0];
                st_d.stat.wp_viol  = st_q.stat.wp_viol & ~reg_wdata[1];
            end
        end
        st_d.stat.conflict = st_d.stat.conflict | set_conflict;
        st_d.stat.wp_viol  = st_d.stat.wp_viol | set_wp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (reg_addr == REG_AW'(i)) begin
                reg_rdata[ADDR_W-1:MIN_LOG2] = st_q.cfg[i].base;
                reg_rdata[CFG_EN]            = st_q.cfg[i].en;
                reg_rdata[CFG_WP]            = st_q.cfg[i].wp;
                reg_rdata[SIZE_W-1:0]        = st_q.cfg[i].size;
            end
        end
        if (reg_addr == REG_CTRL) begin
            reg_rdata[0]                   = st_q.ctrl.conf_en;
            reg_rdata[1]                   = st_q.ctrl.wp_en;
            reg_rdata[2]                   = st_q.ctrl.periph_en;
            reg_rdata[PIN_LSB +: NUM_PINS] = st_q.ctrl.pin_en;
        end
        if (reg_addr == REG_STAT) begin
            reg_rdata[0] = st_q.stat.conflict;
            reg_rdata[1] = st_q.stat.wp_viol;
        end
    end

    assign cfg  = st_q.cfg;
    assign ctrl = st_q.ctrl;
    assign stat = st_q.stat;
endmodule

// File: rtl/cs_fault_decoder.sv
module cs_fault_decoder
    import cfd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                reg_en,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_CS-1:0]   cs_n,
    output logic [NUM_PINS-1:0] periph_cs_n,
    output logic [NUM_PINS-1:0] pin_mode,
    output logic                bus_err
);
    cs_cfg_t [NUM_CS-1:0] cfg;
    ctrl_t                ctrl;
    stat_t                stat;
    logic [NUM_CS-1:0]    hit;
    logic [NUM_CS-1:0]    wp_bits;
    logic                 conflict_w;
    logic                 wp_viol_w;

    cfd_regfile u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_en       (reg_en),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .set_conflict (conflict_w),
        .set_wp       (wp_viol_w),
        .cfg          (cfg),
        .ctrl         (ctrl),
        .stat         (stat),
        .reg_rdata    (reg_rdata)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_region
        if (i == PERIPH_CS) begin : g_periph
            cfd_region_match u_match (
                .addr         (bus_addr),
                .cfg          (cfg[i]),
                .force_periph (ctrl.periph_en),
                .hit          (hit[i])
            );
        end else begin : g_plain
            cfd_region_match u_match (
                .addr         (bus_addr),
                .cfg          (cfg[i]),
                .force_periph (1'b0),
                .hit          (hit[i])
            );
        end
        assign wp_bits[i] = cfg[i].wp;
    end

    cfd_select_out u_out (
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .quarter     (bus_addr[PERIPH_LOG2-1:PERIPH_LOG2-2]),
        .hit         (hit),
        .wp          (wp_bits),
        .ctrl        (ctrl),
        .cs_n        (cs_n),
        .periph_cs_n (periph_cs_n),
        .pin_mode    (pin_mode),
        .conflict    (conflict_w),
        .wp_viol     (wp_viol_w),
        .bus_err     (bus_err)
    );
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker
    import cfd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                reg_en,
    input logic                reg_wr,
    input logic [REG_AW-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [NUM_CS-1:0]   cs_n,
    input logic [NUM_PINS-1:0] periph_cs_n,
    input logic [NUM_PINS-1:0] pin_mode,
    input logic                bus_err,
    input logic                conflict,
    input logic                wp_viol,
    input logic                conf_en,
    input logic                wp_en,
    input logic                flag_conf,
    input logic                flag_wp
);
    logic clr_conf;
    logic clr_wp;
    assign clr_conf = reg_en && reg_wr && (reg_addr == REG_STAT) && reg_wdata[0];
    assign clr_wp   = reg_en && reg_wr && (reg_addr == REG_STAT) && reg_wdata[1];

    // R2: selects only while a bus cycle runs
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (&cs_n && &periph_cs_n));

    // R2: at most one select active at any time
    p_single_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{periph_cs_n, cs_n}));

    // R3: a conflict drives no select
    p_conflict_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (&cs_n && &periph_cs_n));

    // R3: the conflict flag follows a conflict
    p_conflict_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> flag_conf);

    // R5: the protection flag follows a violation
    p_wp_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wp_viol |=> flag_wp);

    // R4 and R6: no bus error without an enabled fault
    p_berr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ((conflict && conf_en) || (wp_viol && wp_en)));

    // R7: flags hold until cleared
    p_sticky_conf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_conf && !clr_conf) |=> flag_conf);
    p_sticky_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wp && !clr_wp) |=> flag_wp);

    // R9 and R10: a pin not in select mode stays high
    p_pin_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pin_mode & ~periph_cs_n) == '0));
endmodule

bind cs_fault_decoder cfd_checker u_cfd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .reg_en      (reg_en),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .cs_n        (cs_n),
    .periph_cs_n (periph_cs_n),
    .pin_mode    (pin_mode),
    .bus_err     (bus_err),
    .conflict    (conflict_w),
    .wp_viol     (wp_viol_w),
    .conf_en     (ctrl.conf_en),
    .wp_en       (ctrl.wp_en),
    .flag_conf   (stat.conflict),
    .flag_wp     (stat.wp_viol)
);

// File: tb/test_cs_fault_decoder.sv
module test_cs_fault_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  cs_n;
    logic [2:0]  periph_cs_n;
    logic [2:0]  pin_mode;
    logic        bus_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    cs_fault_decoder i_cs_fault_decoder (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_n(cs_n),
        .periph_cs_n(periph_cs_n), .pin_mode(pin_mode), .bus_err(bus_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #2 chk(tag, reg_rdata, exp);
        @(posedge clk); #1;
        reg_en = 1'b0;
    endtask

    // one bus cycle; checks cs_n, periph_cs_n and bus_err mid-cycle
    task automatic access(input string tag, input logic v, input logic w, input logic [23:0] a,
                          input logic [3:0] exp_cs, input logic [2:0] exp_p, input logic exp_err);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a;
        #2;
        chk({tag, " cs_n"}, 32'(cs_n), 32'(exp_cs));
        chk({tag, " periph_cs_n"}, 32'(periph_cs_n), 32'(exp_p));
        chk({tag, " bus_err"}, 32'(bus_err), 32'(exp_err));
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic t_reset;
        #2;
        chk("R1 cs_n", 32'(cs_n), 32'hF);
        chk("R1 periph_cs_n", 32'(periph_cs_n), 32'h7);
        chk("R1 pin_mode", 32'(pin_mode), 32'h0);
        chk("R1 bus_err", 32'(bus_err), 32'h0);
        reg_check("R1 ctrl", 4'd4, 32'h0);
        reg_check("R1 status", 4'd5, 32'h0);
        reg_check("R1 cs0 cfg", 4'd0, 32'h0);
    endtask

    task automatic t_decode;
        reg_write(4'd0, 32'h0000_0023);   // 64K at 0
        reg_write(4'd1, 32'h0010_0030);   // 8K at 0x100000, protected
        reg_write(4'd3, 32'h0080_0028);   // 2M at 0x800000
        reg_check("R11 cs1 readback", 4'd1, 32'h0010_0030);
        reg_write(4'd4, 32'h0000_0053);
        reg_check("R11 ctrl readback", 4'd4, 32'h0000_0053);
        reg_write(4'd4, 32'h0);
        access("R2 cs0 inside", 1, 0, 24'h00_1234, 4'b1110, 3'b111, 0);
        access("R2 cs0 past end", 1, 0, 24'h01_0000, 4'b1111, 3'b111, 0);
        access("R2 no valid", 0, 0, 24'h00_1234, 4'b1111, 3'b111, 0);
        access("R2 cs3 last byte", 1, 0, 24'h9F_FFFF, 4'b0111, 3'b111, 0);
        access("R2 cs3 past end", 1, 0, 24'hA0_0000, 4'b1111, 3'b111, 0);
        access("R5 protected read", 1, 0, 24'h10_0100, 4'b1101, 3'b111, 0);
        reg_check("R5 no flag on read", 4'd5, 32'h0);
    endtask

    task automatic t_protect;
        access("R6 violation no enable", 1, 1, 24'h10_0100, 4'b1111, 3'b111, 0);
        reg_check("R5 flag set", 4'd5, 32'h2);
        reg_write(4'd4, 32'h2);
        access("R6 violation enabled", 1, 1, 24'h10_0100, 4'b1111, 3'b111, 1);
        access("R6 plain write", 1, 1, 24'h00_0100, 4'b1110, 3'b111, 0);
        reg_write(4'd5, 32'h0);
        reg_check("R7 zero write keeps flag", 4'd5, 32'h2);
        reg_write(4'd5, 32'h2);
        reg_check("R7 one clears flag", 4'd5, 32'h0);
    endtask

    task automatic t_conflict;
        reg_write(4'd2, 32'h0000_0020);   // 8K at 0, overlaps cs0
        access("R4 conflict no enable", 1, 0, 24'h00_0100, 4'b1111, 3'b111, 0);
        reg_check("R3 conflict flag", 4'd5, 32'h1);
        reg_write(4'd4, 32'h3);
        access("R4 conflict enabled", 1, 0, 24'h00_0100, 4'b1111, 3'b111, 1);
        access("R3 single outside overlap", 1, 0, 24'h00_2000, 4'b1110, 3'b111, 0);
        reg_write(4'd5, 32'h3);
        reg_check("R7 both cleared", 4'd5, 32'h0);
    endtask

    task automatic t_periph;
        reg_write(4'd2, 32'h0020_0020);   // 8K at 0x200000
        reg_write(4'd4, 32'h0000_0057);   // periph on, pins 0 and 2
        #2 chk("R10 pin_mode", 32'(pin_mode), 32'h5);
        access("R9 quarter0", 1, 0, 24'h20_0010, 4'b1011, 3'b111, 0);
        access("R9 quarter1 pin0", 1, 0, 24'h20_4000, 4'b1111, 3'b110, 0);
        access("R9 quarter2 pin off", 1, 0, 24'h20_8000, 4'b1111, 3'b111, 0);
        access("R9 quarter3 pin2", 1, 0, 24'h20_C000, 4'b1111, 3'b011, 0);
        reg_write(4'd4, 32'h0000_0053);   // periph off
        #2 chk("R8 pin_mode off", 32'(pin_mode), 32'h0);
        access("R8 plain cs2", 1, 0, 24'h20_0010, 4'b1011, 3'b111, 0);
        access("R8 8K limit", 1, 0, 24'h20_4000, 4'b1111, 3'b111, 0);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #20 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_protect();
        t_conflict();
        t_periph();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule